// File: doc/BRIEF.md
# Unsigned 8-bit Divide Unit

This block divides an unsigned 8-bit accumulator value by an unsigned 8-bit B value over a fixed number of clock cycles. A one-cycle `start` pulse, taken only while the unit is idle, captures both operands. The unit then runs a restoring shift-subtract division that retires two quotient bits per cycle, so all eight bits are done in four cycles. On completion it writes the quotient to `acc_out` and the remainder to `b_out`. It also updates the carry and overflow flags and raises `done` for one clock.

A zero divisor does not trap. It sets the overflow flag instead. In that case the quotient is all ones (FFh) and the remainder is the original dividend, so the result is fully defined. The carry flag is cleared after every division.

Control is a three-state machine:
- IDLE waits for `start`. The transition IDLE→RUN happens when `start` is seen.
- RUN loops RUN→RUN while its step count is below three.
- RUN→FINISH happens on the fourth step.
- FINISH→IDLE always happens after one cycle.

Top module: `octet_divider`

## Requirements
- R1: On completion of a division with a nonzero divisor, `acc_out` holds the integer quotient of the captured dividend by the captured divisor and `b_out` holds the remainder (e.g. 251 / 18 gives 13 remainder 17).
- R2: `cy_out` is 0 after every completion, whatever the divisor.
- R3: A completion with a nonzero divisor leaves `ov_out` at 0.
- R4: A completion with divisor 00h sets `ov_out` to 1, `acc_out` to FFh and `b_out` to the captured dividend.
- R5: When `start` is accepted at a clock edge, `busy` is high for exactly the next 4 cycles. Results appear and `done` rises at the 4th edge after acceptance.
- R6: `done` is high for exactly one cycle per division, and never together with `busy`.
- R7: `start` is accepted only in IDLE. A `start` while `busy` or `done` is high launches nothing. Operand inputs are not looked at after acceptance.
- R8: After reset all outputs are 0. `acc_out`, `b_out`, `cy_out` and `ov_out` hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a division (taken in IDLE only) |
| acc_in | input | 8 | Dividend |
| b_in | input | 8 | Divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion strobe |
| acc_out | output | 8 | Quotient |
| b_out | output | 8 | Remainder |
| cy_out | output | 1 | Carry flag, cleared on completion |
| ov_out | output | 1 | Overflow flag, set on divide by zero |

## Verification
`start` is applied before an edge. `busy` is then due in the cycle after that edge and stays high for four cycles. The quotient, remainder, flags and `done` are all due together after the fourth edge, and `done` must be gone one cycle later. The driver counts `busy` cycles and checks that the count is exactly four. The scoreboard monitor samples on the falling edge and compares only in the cycle where `done` is high, so each result is checked in the cycle it is due. The checks of held outputs, and of `start` pulses that must be ignored, are made in the cycles between or after completions.

// File: rtl/divu_pkg.sv
package divu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } divu_state_e;
endpackage

// File: rtl/divu_step.sv
// One restoring shift-subtract step: brings in the next dividend bit,
// subtracts the divisor when it fits, and shifts a quotient bit in.
module divu_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W:0] trial;
    logic [W:0] diff;
    logic       fits;

    always_comb begin
        trial = {rem_i, quo_i[W-1]};
        diff  = trial - {1'b0, dvs_i};
        fits  = (trial >= {1'b0, dvs_i});
        rem_o = fits ? diff[W-1:0] : trial[W-1:0];
        quo_o = {quo_i[W-2:0], fits};
    end
endmodule

// File: rtl/divu_fsm.sv
module divu_fsm
    import divu_pkg::*;
#(
    parameter int STEPS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic load,
    output logic last
);
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;

    divu_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (start) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (cnt_q == CNT_W'(STEPS - 1)) begin
                    state_d = ST_FINISH;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == ST_RUN);
        done = (state_q == ST_FINISH);
        load = (state_q == ST_IDLE) && start;
        last = busy && (cnt_q == CNT_W'(STEPS - 1));
    end
endmodule

// File: rtl/octet_divider.sv
module octet_divider #(
    parameter int DATA_W       = 8,
    parameter int BITS_PER_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] b_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] acc_out,
    output logic [DATA_W-1:0] b_out,
    output logic              cy_out,
    output logic              ov_out
);
    localparam int STEPS = DATA_W / BITS_PER_CYC;

    logic              load, last;
    logic [DATA_W-1:0] rem_q, quo_q, dvs_q;
    logic              zero_q;
    logic [DATA_W-1:0] rem_ch [BITS_PER_CYC+1];
    logic [DATA_W-1:0] quo_ch [BITS_PER_CYC+1];

    divu_fsm #(.STEPS(STEPS)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done),
        .load  (load),
        .last  (last)
    );

    assign rem_ch[0] = rem_q;
    assign quo_ch[0] = quo_q;

    for (genvar g = 0; g < BITS_PER_CYC; g++) begin : g_step
        divu_step #(.W(DATA_W)) u_step (
            .rem_i (rem_ch[g]),
            .quo_i (quo_ch[g]),
            .dvs_i (dvs_q),
            .rem_o (rem_ch[g+1]),
            .quo_o (quo_ch[g+1])
        );
    end

    // Working registers: dividend shifts out as quotient shifts in.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            zero_q <= 1'b0;
        end else if (load) begin
            rem_q  <= '0;
            quo_q  <= acc_in;
            dvs_q  <= b_in;
            zero_q <= (b_in == '0);
        end else if (busy) begin
            rem_q  <= rem_ch[BITS_PER_CYC];
            quo_q  <= quo_ch[BITS_PER_CYC];
        end
    end

    // Architectural results, updated only at completion.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_out <= '0;
            b_out   <= '0;
            cy_out  <= 1'b0;
            ov_out  <= 1'b0;
        end else if (last) begin
            acc_out <= quo_ch[BITS_PER_CYC];
            b_out   <= rem_ch[BITS_PER_CYC];
            cy_out  <= 1'b0;
            ov_out  <= zero_q;
        end
    end
endmodule

// File: rtl/divu_chk.sv
module divu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [7:0] acc_in,
    input logic [7:0] b_in,
    input logic       busy,
    input logic       done,
    input logic [7:0] acc_out,
    input logic [7:0] b_out,
    input logic       cy_out,
    input logic       ov_out
);
    AST_QUOT_REM: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(b_in, 5) != 8'd0) |->
        (acc_out == $past(acc_in, 5) / $past(b_in, 5)) &&
        (b_out == $past(acc_in, 5) % $past(b_in, 5)));            // R1
    AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cy_out);                                         // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(b_in, 5) != 8'd0) |-> !ov_out);             // R3
    AST_ZERO_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(b_in, 5) == 8'd0) |->
        (ov_out && acc_out == 8'hFF && b_out == $past(acc_in, 5))); // R4
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy, 1) && $past(busy, 4) && !$past(busy, 5))); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                           // R6
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));                                          // R6
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);                                           // R7
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> ($stable(acc_out) && $stable(b_out) && $stable(ov_out))); // R8
endmodule

bind octet_divider divu_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .acc_in  (acc_in),
    .b_in    (b_in),
    .busy    (busy),
    .done    (done),
    .acc_out (acc_out),
    .b_out   (b_out),
    .cy_out  (cy_out),
    .ov_out  (ov_out)
);

// File: tb/octet_divider_bench.sv
module octet_divider_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] acc_in = '0;
    logic [7:0] b_in = '0;
    logic       busy, done, cy_out, ov_out;
    logic [7:0] acc_out, b_out;

    int checks = 0;
    int fails  = 0;
    int dones  = 0;
    int cycles = 0;
    bit finished = 0;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] q;
        logic [7:0] r;
        logic       ov;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    octet_divider u_octet_divider (
        .clk(clk), .rst_n(rst_n), .start(start), .acc_in(acc_in), .b_in(b_in),
        .busy(busy), .done(done), .acc_out(acc_out), .b_out(b_out),
        .cy_out(cy_out), .ov_out(ov_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: compares each completion against the oldest expected item.
    always @(negedge clk) begin
        cycles++;
        if (rst_n && done) begin
            exp_t e;
            dones++;
            chk(sb.size() > 0, "R7 unexpected completion", 0, 1);
            if (sb.size() > 0) begin
                e = sb.pop_front();
                chk(acc_out == e.q, e.ov ? "R4 quotient FFh" : "R1 quotient", acc_out, e.q);
                chk(b_out == e.r, e.ov ? "R4 remainder=dividend" : "R1 remainder", b_out, e.r);
                chk(ov_out == e.ov, e.ov ? "R4 overflow set" : "R3 overflow clear", ov_out, e.ov);
                chk(cy_out == 1'b0, "R2 carry clear", cy_out, 0);
                chk(!busy, "R6 done without busy", busy, 0);
            end
        end
    end

    // Driver: optionally pokes start during busy, or during done.
    task automatic run_div(input logic [7:0] a, input logic [7:0] b,
                           input bit poke_busy, input bit poke_done);
        exp_t e;
        int   n;
        @(negedge clk);
        acc_in = a;
        b_in   = b;
        start  = 1'b1;
        e.a = a; e.b = b;
        if (b == 0) begin e.q = 8'hFF; e.r = a; e.ov = 1'b1; end
        else begin e.q = a / b; e.r = a % b; e.ov = 1'b0; end
        sb.push_back(e);
        @(negedge clk);
        start  = 1'b0;
        acc_in = ~a;           // R7: operands must not be looked at again
        b_in   = b + 8'd1;
        n = 0;
        while (!done) begin
            if (busy) n++;
            if (poke_busy && n == 2) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        chk(n == 4, "R5 busy cycles", n, 4);
        if (poke_done) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!done, "R6 done one cycle", done, 0);
        chk(!busy, "R7 no restart after ignored start", busy, 0);
        repeat (2) @(negedge clk);
        chk(acc_out == e.q && b_out == e.r && ov_out == e.ov, "R8 outputs held",
            acc_out, e.q);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(acc_out == 0 && b_out == 0 && !cy_out && !ov_out && !busy && !done,
            "R8 reset state", acc_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_div(8'd251, 8'd18, 0, 0);   // R1 worked example
        run_div(8'd0,   8'd5,  0, 0);
        run_div(8'd255, 8'd1,  0, 0);
        run_div(8'd255, 8'd255, 0, 0);
        run_div(8'd7,   8'd9,  0, 0);
        run_div(8'd100, 8'd0,  0, 0);   // R4
        run_div(8'd0,   8'd0,  0, 0);   // R4
        run_div(8'd128, 8'd3,  1, 0);   // R7 start during busy
        run_div(8'd200, 8'd7,  0, 1);   // R7 start during done
        for (int a = 0; a < 256; a += 17)
            for (int b = 0; b < 256; b += 23)
                run_div(8'(a), 8'(b), 0, 0);
        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R7 all expected completions seen", sb.size(), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule